// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Port

This block gives a host a one-byte control register through which it drives a three-wire serial EEPROM by toggling pins in software. The EEPROM wires are shared with a memory port, so before any pin moves the host must ask for the port. The block holds the request until the memory port reports that it is idle, then takes the port and raises a ready flag. The grant is held until the host drops the request.

Once the port is owned, the chip-select, clock and data-out bits of the register appear on the EEPROM pins. The data-in bit returns the EEPROM output. The ready flag then changes meaning. Every register write that keeps the request set drops it, and it rises again after a fixed settle time of about 800 ns. The host polls it between clock edges of its serial sequence. When the port is not owned, pin values written by the host are kept in the register but not driven, and the pins rest low.

Top module: `seeprom_port`

## Requirements
- R1: After reset the register reads 0x00 (with the external acknowledge input low), the grant output is low and the three EEPROM output pins are low.
- R2: Register bits 6 (external request), 5 (port request), 3 (chip select), 2 (clock) and 1 (data out) are stored on a write and read back. Writes to bits 7, 4 and 0 have no effect. Bit 7 reads the external acknowledge input. Bit 6 drives the external request output.
- R3: While the port request bit is set and the memory port reports busy, no grant is given. The grant rises on the first clock edge at which the request is set and busy is low.
- R4: When the grant is given, ready (bit 4) is high in the same cycle as the grant, with no settle delay.
- R5: While the port is owned, a write that keeps bit 5 set makes ready read 0 after the write edge. Ready stays 0 for exactly SETTLE_CYC clock edges, then reads 1 (SETTLE_CYC = ceil(SETTLE_NS / CLK_PERIOD_NS), 200 by default).
- R6: While the port is owned, the chip-select, clock and data-out pins equal register bits 3, 2 and 1.
- R7: While the port is owned, bit 0 reads the EEPROM data input as sampled on the previous clock edge. When the port is not owned, bit 0 reads 0.
- R8: While the port is not owned, the three EEPROM output pins are low, whatever values are stored in bits 3, 2 and 1.
- R9: A write with bit 5 clear releases the port on that edge. Grant, ready and the output pins are low afterwards, while bits 3, 2 and 1 keep the written values.
- R10: Once the port is owned, the memory-port busy input has no effect on the grant or on ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| mem_busy | input | 1 | Memory port busy with another request |
| ext_arb_ack | input | 1 | External arbitration acknowledge, read as bit 7 |
| ext_arb_req | output | 1 | External arbitration request, driven from bit 6 |
| eep_grant | output | 1 | EEPROM owns the shared pins; memory port must stay off |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | EEPROM serial data to the device |
| ee_miso | input | 1 | EEPROM serial data from the device |

## Verification
The assertions check the following on every cycle:
- pins stay low without a grant;
- ready never shows without a grant;
- a grant only rises after a cycle with the memory port idle;
- ready and grant only fall on a write;
- an owned write drops ready on the next cycle;
- a release write ends the grant.

Other behaviour can only be shown by the directed scenarios:
- the exact length of the settle window;
- the immediate ready on the initial grant;
- the register readback of each field;
- the one-cycle sampling of the data input;
- the indifference to busy after the grant.

// File: rtl/seep_pkg.sv
// Shared definitions for the serial EEPROM port.
// Assumes an 8-bit control register whose bit positions are fixed
// because host software decodes them.
package seep_pkg;
    localparam int CTL_W    = 8;
    localparam int BIT_XACK = 7;
    localparam int BIT_XREQ = 6;
    localparam int BIT_PREQ = 5;
    localparam int BIT_RDY  = 4;
    localparam int BIT_CS   = 3;
    localparam int BIT_SCK  = 2;
    localparam int BIT_DO   = 1;
    localparam int BIT_DI   = 0;
    localparam int PIN_N    = 3;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic xreq;
        logic preq;
        logic cs;
        logic sck;
        logic dout;
    } ctl_bits_t;
endpackage

// File: rtl/seep_ctrl_reg.sv
// Storage for the writable control bits.
// Assumes single-cycle write strobes. The read-only positions (7, 4, 0)
// are dropped here. It also gives the request value that will hold after
// this edge, so that the arbiter can act in the same cycle as the write.
module seep_ctrl_reg
    import seep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_bits_t        bits,
    output logic             req_nxt
);
    logic unused_ro_bits;

    // Latch the writable fields on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (wr) begin
            bits.xreq <= wdata[BIT_XREQ];
            bits.preq <= wdata[BIT_PREQ];
            bits.cs   <= wdata[BIT_CS];
            bits.sck  <= wdata[BIT_SCK];
            bits.dout <= wdata[BIT_DO];
        end
    end

    // Request level that takes effect at this edge.
    always_comb begin
        req_nxt = wr ? wdata[BIT_PREQ] : bits.preq;
    end

    assign unused_ro_bits = ^{wdata[BIT_XACK], wdata[BIT_RDY], wdata[BIT_DI]};
endmodule

// File: rtl/seep_arbiter.sv
// Arbitration for the shared memory port.
// A pending request waits while the memory port is busy. It takes
// ownership on the first edge at which busy is low. Once owned, busy is
// ignored, and only a dropped request returns the FSM to idle.
module seep_arbiter
    import seep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_nxt,
    input  logic mem_busy,
    output logic granted
);
    arb_state_t state_q, state_d;

    // Next-state choice for the ownership FSM.
    always_comb begin
        state_d = state_q;
        if (!req_nxt) begin
            state_d = ARB_IDLE;
        end else begin
            unique case (state_q)
                ARB_OWN:  state_d = ARB_OWN;
                ARB_IDLE,
                ARB_WAIT: state_d = mem_busy ? ARB_WAIT : ARB_OWN;
                default:  state_d = ARB_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    assign granted = (state_q == ARB_OWN);
endmodule

// File: rtl/seep_settle_timer.sv
// Down-counter that times the settle window after an owned write.
// The done flag is high when the count is zero. A load keeps done low
// for exactly CYC edges. Clear forces zero, so a fresh grant is ready at once.
module seep_settle_timer #(
    parameter int unsigned CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic done
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYC);

    logic [CW-1:0] cnt_q;

    // Count down from the load value, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/seeprom_port.sv
// Host-facing serial EEPROM port with memory-port arbitration.
// Assumes the host writes with one-cycle strobes and reads reg_rdata at
// any time. Pins are driven only while the port is owned. The data input
// is sampled once per clock.
module seeprom_port
    import seep_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned SETTLE_NS     = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             mem_busy,
    input  logic             ext_arb_ack,
    output logic             ext_arb_req,
    output logic             eep_grant,
    output logic             ee_cs,
    output logic             ee_sck,
    output logic             ee_mosi,
    input  logic             ee_miso
);
    localparam int unsigned SETTLE_CYC =
        (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    ctl_bits_t        bits;
    logic             req_nxt;
    logic             granted;
    logic             settle_done;
    logic             di_q;
    logic [PIN_N-1:0] pin_src;
    logic [PIN_N-1:0] pin_out;

    seep_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .bits    (bits),
        .req_nxt (req_nxt)
    );

    seep_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_nxt  (req_nxt),
        .mem_busy (mem_busy),
        .granted  (granted)
    );

    seep_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!granted),
        .load  (reg_wr && granted && reg_wdata[BIT_PREQ]),
        .done  (settle_done)
    );

    // Sample the EEPROM data output while the port is owned.
    always_ff @(posedge clk) begin
        if (!rst_n) di_q <= 1'b0;
        else        di_q <= granted & ee_miso;
    end

    // Gate each output pin by ownership.
    assign pin_src = {bits.cs, bits.sck, bits.dout};
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        assign pin_out[i] = granted & pin_src[i];
    end

    assign ee_cs       = pin_out[2];
    assign ee_sck      = pin_out[1];
    assign ee_mosi     = pin_out[0];
    assign eep_grant   = granted;
    assign ext_arb_req = bits.xreq;

    // Assemble the read view of the control register.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[BIT_XACK] = ext_arb_ack;
        reg_rdata[BIT_XREQ] = bits.xreq;
        reg_rdata[BIT_PREQ] = bits.preq;
        reg_rdata[BIT_RDY]  = granted & settle_done;
        reg_rdata[BIT_CS]   = bits.cs;
        reg_rdata[BIT_SCK]  = bits.sck;
        reg_rdata[BIT_DO]   = bits.dout;
        reg_rdata[BIT_DI]   = granted & di_q;
    end
endmodule

// File: rtl/seeprom_port_chk.sv
// Protocol checker for seeprom_port, bound to every instance.
// Observes ports only. Assumes the synchronous active-low reset.
module seeprom_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       mem_busy,
    input logic       eep_grant,
    input logic       ee_cs,
    input logic       ee_sck,
    input logic       ee_mosi
);
    assert_pins_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !eep_grant |-> (!ee_cs && !ee_sck && !ee_mosi));

    assert_ready_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |-> eep_grant);

    assert_grant_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eep_grant) |-> $past(!mem_busy));

    assert_write_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[5] && eep_grant) |=> !reg_rdata[4]);

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !reg_wr) |=> reg_rdata[4]);

    assert_grant_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_grant && !reg_wr) |=> eep_grant);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[5]) |=> !eep_grant);
endmodule

bind seeprom_port seeprom_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_busy  (mem_busy),
    .eep_grant (eep_grant),
    .ee_cs     (ee_cs),
    .ee_sck    (ee_sck),
    .ee_mosi   (ee_mosi)
);

// File: tb/tb_seeprom_port.sv
// Directed bench for seeprom_port: one task per scenario.
// Inputs change and outputs are sampled on falling edges.
module tb_seeprom_port;
    localparam int SETTLE = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mem_busy = 1'b0;
    logic       ext_arb_ack = 1'b0;
    logic       ext_arb_req;
    logic       eep_grant;
    logic       ee_cs, ee_sck, ee_mosi;
    logic       ee_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seeprom_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_busy(mem_busy), .ext_arb_ack(ext_arb_ack),
        .ext_arb_req(ext_arb_req), .eep_grant(eep_grant), .ee_cs(ee_cs),
        .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Write at the current falling edge; returns one falling edge later.
    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] pins();
        return {5'd0, ee_cs, ee_sck, ee_mosi};
    endfunction

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 grant", {7'd0, eep_grant}, 8'h00);
        chk("R1 pins", pins(), 8'h00);
    endtask

    task automatic t_fields;
        mem_busy = 1'b1;
        wr(8'hFF);
        chk("R2 readback", reg_rdata, 8'h6E);
        chk("R2 ext req", {7'd0, ext_arb_req}, 8'h01);
        ext_arb_ack = 1'b1;
        #1;
        chk("R2 ext ack", {7'd0, reg_rdata[7]}, 8'h01);
        chk("R8 pins gated", pins(), 8'h00);
        @(negedge clk);
        ext_arb_ack = 1'b0;
        wr(8'h00);
        chk("R2 cleared", reg_rdata, 8'h00);
        mem_busy = 1'b0;
    endtask

    task automatic t_wait_busy;
        mem_busy = 1'b1;
        wr(8'h2A);
        chk("R3 no grant", {7'd0, eep_grant}, 8'h00);
        wait_n(5);
        chk("R3 still waiting", {7'd0, eep_grant}, 8'h00);
        chk("R8 pins while waiting", pins(), 8'h00);
        mem_busy = 1'b0;
        @(negedge clk);
        chk("R3 grant", {7'd0, eep_grant}, 8'h01);
        chk("R4 ready at grant", {7'd0, reg_rdata[4]}, 8'h01);
        chk("R6 pins on grant", pins(), 8'h05);
    endtask

    task automatic t_settle;
        wr(8'h28);
        chk("R5 ready low", {7'd0, reg_rdata[4]}, 8'h00);
        chk("R6 cs only", pins(), 8'h04);
        wait_n(SETTLE - 1);
        chk("R5 ready still low", {7'd0, reg_rdata[4]}, 8'h00);
        @(negedge clk);
        chk("R5 ready back", {7'd0, reg_rdata[4]}, 8'h01);
    endtask

    task automatic t_pins;
        wr(8'h2E);
        chk("R6 all pins", pins(), 8'h07);
        wr(8'h24);
        chk("R6 sck only", pins(), 8'h02);
    endtask

    task automatic t_datain;
        ee_miso = 1'b1;
        @(negedge clk);
        chk("R7 di high", {7'd0, reg_rdata[0]}, 8'h01);
        ee_miso = 1'b0;
        @(negedge clk);
        chk("R7 di low", {7'd0, reg_rdata[0]}, 8'h00);
    endtask

    task automatic t_busy_ignored;
        wait_n(SETTLE);
        mem_busy = 1'b1;
        wait_n(3);
        chk("R10 grant kept", {7'd0, eep_grant}, 8'h01);
        chk("R10 ready kept", {7'd0, reg_rdata[4]}, 8'h01);
        mem_busy = 1'b0;
    endtask

    task automatic t_release;
        ee_miso = 1'b1;
        wr(8'h0E);
        chk("R9 grant off", {7'd0, eep_grant}, 8'h00);
        chk("R9 pins off", pins(), 8'h00);
        chk("R9 readback", reg_rdata, 8'h0E);
        chk("R7 di unowned", {7'd0, reg_rdata[0]}, 8'h00);
        ee_miso = 1'b0;
        wr(8'h20);
        chk("R4 regrant ready", {7'd0, reg_rdata[4]}, 8'h01);
        chk("R4 regrant", {7'd0, eep_grant}, 8'h01);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fields;
        t_wait_busy;
        t_settle;
        t_pins;
        t_datain;
        t_busy_ignored;
        t_release;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule